// File: doc/BRIEF.md
# Timer Output Configuration Guard

This block holds the output-stage settings of a multi-channel timer: per-output idle levels, an 8-bit deadtime code, break and automatic-output-enable controls, the run and idle off-state selections, and per-channel direction, polarity, compare mode and preload bits. Software reaches all of them through one register port with address, write data, write strobe and read data. Every stored field is also driven straight out of the block for the output stage.

A 2-bit protection level sets which fields bus writes can still change. The four levels are cumulative. The level itself can be written once after reset: the first write to the control word sets it, and it then stays fixed until the next reset. The break, auto-enable and off-state bits live in that same word, so they are taken from that first write before any protection applies. Polarity, mode and preload are guarded only while their channel is set as an output. A write that hits guarded fields still updates the unguarded fields of the same word.

Top module: `tim_cfg_guard`

## Requirements
- R1: While rst_ni is low and after it rises, every stored field, the protection level and the first-write flag are zero, and all reads return 0.
- R2: Only the first write to the control word (address 2) after reset loads the level from bits [1:0]. Later writes leave the level unchanged, even if the first write set it to 0.
- R3: The first control-word write loads off_idle (bit 2), off_run (bit 3), break enable (bit 4), break polarity (bit 5) and auto output enable (bit 6), whatever level it sets.
- R4: At level 0, writes to every field take effect on the next clock edge.
- R5: At level 1 or higher, writes to the idle word (address 0), the deadtime code (address 1) and the break enable, break polarity and auto output enable bits are ignored.
- R6: At level 2 or higher, writes to the off-state bits are ignored, and so are writes to the polarity bit of any channel whose stored direction is output.
- R7: At level 3, writes to the mode and preload bits of any channel whose stored direction is output are ignored.
- R8: Channel c sits at address 4+c with direction [1:0] (00 = output, any other value = input), polarity [2], mode [5:3] and preload [6]. Direction is always writable. Protection uses the direction stored before the write, so a channel set to input can have its polarity and mode changed from the next write on.
- R9: In a write where some fields are guarded, the unguarded fields of the same word are still updated.
- R10: Reads are combinational from addr_i. The idle word maps bit 2c to the main output of channel c and bit 2c+1 to its complementary output (channels 0..NUM_CH-2), with the top bit for the last channel's main output. Address 3, unused bits and bit 7 of the control word read 0.
- R11: The exported outputs always equal the stored field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| lock_level_o | output | 2 | Current protection level |
| idle_o | output | 2*NUM_CH-1 | Idle levels of the outputs |
| dt_code_o | output | 8 | Deadtime code |
| brk_en_o | output | 1 | Break enable |
| brk_pol_o | output | 1 | Break polarity |
| auto_oe_o | output | 1 | Automatic output enable |
| off_run_o | output | 1 | Run-mode off-state selection |
| off_idle_o | output | 1 | Idle-mode off-state selection |
| ch_dir_o | output | 2*NUM_CH | Channel directions |
| ch_pol_o | output | NUM_CH | Channel polarities |
| ch_mode_o | output | 3*NUM_CH | Channel compare modes |
| ch_pre_o | output | NUM_CH | Channel preload enables |

## Verification
On every cycle the assertions check that the level cannot change once the first-write flag is set and that the flag never drops outside reset. They also check that a write to a guarded field at the matching level leaves the exported value stable, with polarity and mode gated by the channel's stored direction, and that the direction always follows the written value. Only the bench scenarios can show the rest: the first control write capturing all of its bits, the freeze of a level left at 0, unguarded fields updating in the same word as guarded ones, the read bit layout, and a channel becoming writable again one write after it is switched to input.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    LVL_OPEN = 2'd0,
    LVL_1    = 2'd1,
    LVL_2    = 2'd2,
    LVL_3    = 2'd3
  } lock_lvl_e;

  localparam logic [ADDR_W-1:0] A_IDLE = 3'd0;
  localparam logic [ADDR_W-1:0] A_DT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd2;
  localparam int               CH_BASE = 4;

  // control word bit positions
  localparam int B_OFF_IDLE = 2;
  localparam int B_OFF_RUN  = 3;
  localparam int B_BRK_EN   = 4;
  localparam int B_BRK_POL  = 5;
  localparam int B_AUTO_OE  = 6;

  localparam logic [1:0] DIR_OUT = 2'b00;
endpackage

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_guard_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ctl_we_i,
  input  logic [1:0] lvl_wdata_i,
  output lock_lvl_e level_o,
  output logic      frozen_o
);
  lock_lvl_e level_q;
  logic      frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= LVL_OPEN;
      frozen_q <= 1'b0;
    end else if (ctl_we_i && !frozen_q) begin
      level_q  <= lock_lvl_e'(lvl_wdata_i);
      frozen_q <= 1'b1;
    end
  end

  assign level_o  = level_q;
  assign frozen_o = frozen_q;
endmodule

// File: rtl/cfg_glob_regs.sv
module cfg_glob_regs
  import cfg_guard_pkg::*;
#(
  parameter int IDLE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_we_i,
  input  logic              dt_we_i,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  lock_lvl_e         level_i,
  output logic [IDLE_W-1:0] idle_o,
  output logic [DATA_W-1:0] dt_o,
  output logic              brk_en_o,
  output logic              brk_pol_o,
  output logic              auto_oe_o,
  output logic              off_run_o,
  output logic              off_idle_o
);
  logic tier1_open, tier2_open;
  assign tier1_open = (level_i == LVL_OPEN);
  assign tier2_open = (level_i == LVL_OPEN) || (level_i == LVL_1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_o <= '0;
      dt_o   <= '0;
    end else if (tier1_open) begin
      if (idle_we_i) idle_o <= wdata_i[IDLE_W-1:0];
      if (dt_we_i)   dt_o   <= wdata_i;
    end
  end

  // level is still open before the first control write, so those bits land
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_en_o  <= 1'b0;
      brk_pol_o <= 1'b0;
      auto_oe_o <= 1'b0;
    end else if (ctl_we_i && tier1_open) begin
      brk_en_o  <= wdata_i[B_BRK_EN];
      brk_pol_o <= wdata_i[B_BRK_POL];
      auto_oe_o <= wdata_i[B_AUTO_OE];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_run_o  <= 1'b0;
      off_idle_o <= 1'b0;
    end else if (ctl_we_i && tier2_open) begin
      off_run_o  <= wdata_i[B_OFF_RUN];
      off_idle_o <= wdata_i[B_OFF_IDLE];
    end
  end
endmodule

// File: rtl/cfg_chan_reg.sv
module cfg_chan_reg
  import cfg_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  lock_lvl_e         level_i,
  output logic [1:0]        dir_o,
  output logic              pol_o,
  output logic [2:0]        mode_o,
  output logic              pre_o
);
  logic is_out, pol_open, mode_open;
  assign is_out    = (dir_o == DIR_OUT);
  assign pol_open  = !is_out || (level_i == LVL_OPEN) || (level_i == LVL_1);
  assign mode_open = !is_out || (level_i != LVL_3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= DIR_OUT;
      pol_o  <= 1'b0;
      mode_o <= '0;
      pre_o  <= 1'b0;
    end else if (we_i) begin
      dir_o <= wdata_i[1:0];
      if (pol_open) pol_o <= wdata_i[2];
      if (mode_open) begin
        mode_o <= wdata_i[5:3];
        pre_o  <= wdata_i[6];
      end
    end
  end
endmodule

// File: rtl/tim_cfg_guard.sv
module tim_cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [1:0]            lock_level_o,
  output logic [2*NUM_CH-2:0]   idle_o,
  output logic [DATA_W-1:0]     dt_code_o,
  output logic                  brk_en_o,
  output logic                  brk_pol_o,
  output logic                  auto_oe_o,
  output logic                  off_run_o,
  output logic                  off_idle_o,
  output logic [2*NUM_CH-1:0]   ch_dir_o,
  output logic [NUM_CH-1:0]     ch_pol_o,
  output logic [3*NUM_CH-1:0]   ch_mode_o,
  output logic [NUM_CH-1:0]     ch_pre_o
);
  localparam int IDLE_W = 2*NUM_CH-1;

  lock_lvl_e level;
  logic      frozen;
  logic      ctl_we;

  assign ctl_we = we_i && (addr_i == A_CTL);

  cfg_lock_ctrl u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we),
    .lvl_wdata_i (wdata_i[1:0]),
    .level_o     (level),
    .frozen_o    (frozen)
  );

  cfg_glob_regs #(.IDLE_W(IDLE_W)) u_glob (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_we_i  (we_i && (addr_i == A_IDLE)),
    .dt_we_i    (we_i && (addr_i == A_DT)),
    .ctl_we_i   (ctl_we),
    .wdata_i    (wdata_i),
    .level_i    (level),
    .idle_o     (idle_o),
    .dt_o       (dt_code_o),
    .brk_en_o   (brk_en_o),
    .brk_pol_o  (brk_pol_o),
    .auto_oe_o  (auto_oe_o),
    .off_run_o  (off_run_o),
    .off_idle_o (off_idle_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cfg_chan_reg u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i && (addr_i == ADDR_W'(CH_BASE + c))),
      .wdata_i (wdata_i),
      .level_i (level),
      .dir_o   (ch_dir_o[2*c +: 2]),
      .pol_o   (ch_pol_o[c]),
      .mode_o  (ch_mode_o[3*c +: 3]),
      .pre_o   (ch_pre_o[c])
    );
  end

  assign lock_level_o = level;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_IDLE) rdata_o[IDLE_W-1:0] = idle_o;
    if (addr_i == A_DT)   rdata_o = dt_code_o;
    if (addr_i == A_CTL) begin
      rdata_o[1:0]        = level;
      rdata_o[B_OFF_IDLE] = off_idle_o;
      rdata_o[B_OFF_RUN]  = off_run_o;
      rdata_o[B_BRK_EN]   = brk_en_o;
      rdata_o[B_BRK_POL]  = brk_pol_o;
      rdata_o[B_AUTO_OE]  = auto_oe_o;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(CH_BASE + c))
        rdata_o = {1'b0, ch_pre_o[c], ch_mode_o[3*c +: 3], ch_pol_o[c], ch_dir_o[2*c +: 2]};
    end
  end
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk
  import cfg_guard_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [1:0]          level,
  input logic                frozen,
  input logic [2*NUM_CH-2:0] idle,
  input logic [DATA_W-1:0]   dt,
  input logic                brk_en,
  input logic                off_run,
  input logic                off_idle,
  input logic [2*NUM_CH-1:0] dir,
  input logic [NUM_CH-1:0]   pol,
  input logic [3*NUM_CH-1:0] mode,
  input logic [NUM_CH-1:0]   pre
);
  AST_LEVEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |=> $stable(level)); // R2
  AST_FLAG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |=> frozen); // R2
  AST_DT_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DT && level != 2'd0) |=> $stable(dt)); // R5
  AST_IDLE_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_IDLE && level != 2'd0) |=> $stable(idle)); // R5
  AST_BRK_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTL && level != 2'd0) |=> $stable(brk_en)); // R5
  AST_OFF_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTL && level[1]) |=> ($stable(off_run) && $stable(off_idle))); // R6

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_POL_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(CH_BASE + c) && level[1] && dir[2*c +: 2] == DIR_OUT)
        |=> $stable(pol[c])); // R6
    AST_MODE_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(CH_BASE + c) && level == 2'd3 && dir[2*c +: 2] == DIR_OUT)
        |=> ($stable(mode[3*c +: 3]) && $stable(pre[c]))); // R7
    AST_DIR_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(CH_BASE + c))
        |=> (dir[2*c +: 2] == $past(wdata_i[1:0]))); // R8
  end
endmodule

bind tim_cfg_guard cfg_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .level    (lock_level_o),
  .frozen   (frozen),
  .idle     (idle_o),
  .dt       (dt_code_o),
  .brk_en   (brk_en_o),
  .off_run  (off_run_o),
  .off_idle (off_idle_o),
  .dir      (ch_dir_o),
  .pol      (ch_pol_o),
  .mode     (ch_mode_o),
  .pre      (ch_pre_o)
);

// File: tb/tb_tim_cfg_guard.sv
`timescale 1ns/1ps
module tb_tim_cfg_guard;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [1:0]  lock_level_o;
  logic [6:0]  idle_o;
  logic [7:0]  dt_code_o;
  logic        brk_en_o, brk_pol_o, auto_oe_o, off_run_o, off_idle_o;
  logic [7:0]  ch_dir_o;
  logic [3:0]  ch_pol_o;
  logic [11:0] ch_mode_o;
  logic [3:0]  ch_pre_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tim_cfg_guard #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .lock_level_o(lock_level_o), .idle_o(idle_o), .dt_code_o(dt_code_o),
    .brk_en_o(brk_en_o), .brk_pol_o(brk_pol_o), .auto_oe_o(auto_oe_o),
    .off_run_o(off_run_o), .off_idle_o(off_idle_o), .ch_dir_o(ch_dir_o),
    .ch_pol_o(ch_pol_o), .ch_mode_o(ch_mode_o), .ch_pre_o(ch_pre_o)
  );

  // reference model
  logic [1:0] m_lvl;
  logic       m_frz;
  logic [6:0] m_idle;
  logic [7:0] m_dt;
  logic       m_brk, m_bpol, m_aoe, m_orun, m_oidle;
  logic [1:0] m_dir [NCH];
  logic       m_pol [NCH];
  logic [2:0] m_mode[NCH];
  logic       m_pre [NCH];

  function automatic void m_reset();
    m_lvl = 0; m_frz = 0; m_idle = 0; m_dt = 0;
    m_brk = 0; m_bpol = 0; m_aoe = 0; m_orun = 0; m_oidle = 0;
    for (int c = 0; c < NCH; c++) begin
      m_dir[c] = 0; m_pol[c] = 0; m_mode[c] = 0; m_pre[c] = 0;
    end
  endfunction

  function automatic void m_write(logic [2:0] a, logic [7:0] d);
    if (a == 0) begin
      if (m_lvl == 0) m_idle = d[6:0];
    end else if (a == 1) begin
      if (m_lvl == 0) m_dt = d;
    end else if (a == 2) begin
      if (!m_frz) begin
        m_oidle = d[2]; m_orun = d[3]; m_brk = d[4]; m_bpol = d[5]; m_aoe = d[6];
        m_lvl = d[1:0]; m_frz = 1;
      end else begin
        if (m_lvl == 0) begin m_brk = d[4]; m_bpol = d[5]; m_aoe = d[6]; end
        if (m_lvl < 2)  begin m_oidle = d[2]; m_orun = d[3]; end
      end
    end else if (a >= 4) begin
      int c = int'(a) - 4;
      logic outp = (m_dir[c] == 2'b00);
      if (!(m_lvl >= 2 && outp)) m_pol[c] = d[2];
      if (!(m_lvl == 3 && outp)) begin m_mode[c] = d[5:3]; m_pre[c] = d[6]; end
      m_dir[c] = d[1:0];
    end
  endfunction

  function automatic logic [7:0] m_read(logic [2:0] a);
    logic [7:0] r = 0;
    case (a)
      3'd0: r = {1'b0, m_idle};
      3'd1: r = m_dt;
      3'd2: r = {1'b0, m_aoe, m_bpol, m_brk, m_orun, m_oidle, m_lvl};
      3'd3: r = 0;
      default: begin
        int c = int'(a) - 4;
        r = {1'b0, m_pre[c], m_mode[c], m_pol[c], m_dir[c]};
      end
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(logic [2:0] a);
    if (m_lvl == 0) return "R4";
    if (a <= 1) return "R5";
    if (a == 2) return (m_lvl >= 2) ? "R6" : "R5";
    return (m_lvl == 3) ? "R7" : "R6";
  endfunction

  task automatic check_all(string tag);
    logic [7:0] ed = 0, ep = 0, epr = 0;
    logic [11:0] em = 0;
    for (int a = 0; a < 8; a++) begin
      addr_i = 3'(a);
      #0.5;
      chk(tag, rdata_o, m_read(3'(a)));
    end
    for (int c = 0; c < NCH; c++) begin
      ed[2*c +: 2] = m_dir[c]; ep[c] = m_pol[c]; em[3*c +: 3] = m_mode[c]; epr[c] = m_pre[c];
    end
    chk({tag, " R11 exports"},
        {lock_level_o, idle_o, dt_code_o, brk_en_o, brk_pol_o, auto_oe_o, off_run_o, off_idle_o},
        {m_lvl, m_idle, m_dt, m_brk, m_bpol, m_aoe, m_orun, m_oidle});
    chk({tag, " R11 channels"}, {ch_dir_o, ch_pol_o, ch_mode_o, ch_pre_o},
        {ed, ep[3:0], em, epr[3:0]});
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 0;
    m_write(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    m_reset();
    #1;
    check_all("R1 in reset");
    @(negedge clk);
    rst_ni = 1;
    check_all("R1 after reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    m_reset();
    do_reset();
    for (int lv = 0; lv < 4; lv++) begin
      do_reset();
      // open phase: everything writable
      for (int i = 0; i < 20; i++) begin
        logic [2:0] a;
        do a = 3'($urandom_range(7, 0)); while (a == 2);
        wr(a, 8'($urandom));
        check_all("R4 open");
      end
      // channels 2,3 to input so guarded tiers leave them writable
      wr(3'd6, 8'h01);
      wr(3'd7, 8'h7E);
      // first control write with all side bits set
      wr(3'd2, {1'b0, 5'b11111, 2'(lv)});
      check_all("R3 first ctl");
      chk("R2 level loaded", lock_level_o, lv);
      // second write tries a different level and clears bits
      wr(3'd2, {6'd0, 2'(3 - lv)});
      chk("R2 level frozen", lock_level_o, lv);
      check_all("R2 second ctl");
      // directed: output channel 0 switched to input while writing pol/mode
      wr(3'd4, 8'h00);
      wr(3'd4, 8'h7E);
      check_all("R9 mixed word");
      chk("R8 dir follows write", ch_dir_o[1:0], 2'b10);
      wr(3'd4, 8'h01);
      chk("R8 pol writable after input", ch_pol_o[0], 1'b0);
      chk("R8 mode writable after input", ch_mode_o[2:0], 3'b000);
      check_all("R8 reopened");
      // random traffic
      for (int i = 0; i < 300; i++) begin
        logic [2:0] a = 3'($urandom_range(7, 0));
        string t = tag_for(a);
        wr(a, 8'($urandom));
        check_all(t);
      end
      // mid-run reset clears everything including the freeze
      do_reset();
      wr(3'd1, 8'hA5);
      chk("R1 unlocked after reset", dt_code_o, 8'hA5);
      chk("R10 unused addr", m_read(3'd3), 8'h00);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule